// File: doc/BRIEF.md
# Low-Power Mode Selector with Pin Hold

The block holds one 8-bit control register that decides what a sleep request does. One bit picks the target state: light sleep or deep standby. A second bit picks how the I/O pins behave while in standby. The pins either keep the output value and output-enable they had on entry, or all output enables are released so the pins float. The register is read and written through a plain single-cycle register port. Reads are combinational.

A watchdog-running input protects the two control bits. While it is high, a write can clear either bit but cannot set it. The CPU-side pin signals pass through the block to the pad-side signals. In standby they are replaced by hold registers or by a forced-off output enable. All pins here are plain control signals. None of the interfaces carries a data stream, so there is no valid/ready handshake and no back-pressure.

Top module: `lpm_ctrl`

## Requirements
- R1: After reset the register reads 0x1F and both the sleep flag and the standby flag are 0.
- R2: With `wdt_run` low, a write to the register loads bit 7 (mode: 0 = sleep, 1 = standby) and bit 6 (pin float: 0 = hold, 1 = high impedance) from `wdata`. The new value is visible from the cycle after the write edge.
- R3: With `wdt_run` high, a write that would change bit 7 from 0 to 1 leaves bit 7 at 0.
- R4: With `wdt_run` high, a write that would change bit 6 from 0 to 1 leaves bit 6 at 0.
- R5: A write of 0 to bit 7 or to bit 6 clears that bit whatever the level of `wdt_run`.
- R6: Bit 5 always reads 0 and bits 4..0 always read 1, whatever value was written.
- R7: The register sits at address `REG_ADDR` (default 0). `rdata` shows the register in the same cycle as `rd_en` and a matching `addr`, and is 0 otherwise. Writes to any other address change nothing.
- R8: A one-cycle `sleep_req` while no flag is set samples bit 7 at that edge. From the next cycle exactly one of the two flags is set: `sleep_flag` if bit 7 was 0, `stby_flag` if it was 1.
- R9: A set flag stays set until `wake` is high at a clock edge. Both flags are 0 from the next cycle.
- R10: A `sleep_req` while a flag is set has no effect on the flags or the pins.
- R11: On entering standby with bit 6 at 0, every pin's `core_out` and `core_oe` are captured at the entry edge. `pad_out` and `pad_oe` then show the captured values until wake, whatever the core drives.
- R12: On entering standby with bit 6 at 1, `pad_oe` is all zeros until wake.
- R13: Outside standby, including in sleep, `pad_out` equals `core_out` and `pad_oe` equals `core_oe` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational |
| wdt_run | input | 1 | High while the watchdog is counting; blocks setting bits 7 and 6 |
| sleep_req | input | 1 | One-cycle request to enter the selected low-power state |
| wake | input | 1 | Returns the block to run state |
| core_out | input | NUM_PINS | Pin output values from the core |
| core_oe | input | NUM_PINS | Pin output enables from the core |
| pad_out | output | NUM_PINS | Pin output values to the pads |
| pad_oe | output | NUM_PINS | Pin output enables to the pads |
| sleep_flag | output | 1 | Set while in sleep |
| stby_flag | output | 1 | Set while in standby |

## Verification
On every cycle, the assertions check several things. Protected bits never rise under a running watchdog, and a cleared bit always clears. A request from run state always raises a flag, flags are stable until wake, and wake drops them. Pads stay frozen through a held standby and stay disabled through a floating one. Only the bench scenarios show the rest. These are the exact read values, including the reserved bits and the address decode, and which flag is chosen for each mode bit. They also cover the values captured at the entry edge and the return to pass-through after wake.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  localparam int unsigned REG_W        = 8;
  localparam int unsigned MODE_POS     = 7;
  localparam int unsigned FLOAT_POS    = 6;
  localparam logic        RSVD_HI_VAL  = 1'b0;
  localparam logic [4:0]  RSVD_LO_VAL  = 5'h1F;

  typedef enum logic [1:0] {
    PM_RUN   = 2'd0,
    PM_SLEEP = 2'd1,
    PM_STBY  = 2'd2
  } pm_state_e;

  // A protected bit may always fall, but may rise only when the watchdog is idle.
  function automatic logic guarded_next(input logic wr_val, input logic cur, input logic wdt);
    return wr_val & (cur | ~wdt);
  endfunction
endpackage

// File: rtl/lpm_cfg_reg.sv
module lpm_cfg_reg
  import lpm_pkg::*;
#(
  parameter int unsigned ADDR_W   = 4,
  parameter int unsigned REG_ADDR = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wdata,
  input  logic              wdt_run,
  output logic              mode_sel,
  output logic              float_sel,
  output logic [REG_W-1:0]  rdata
);
  localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(REG_ADDR);

  logic hit_wr, hit_rd;
  logic mode_q, float_q;

  assign hit_wr = wr_en && (addr == MY_ADDR);
  assign hit_rd = rd_en && (addr == MY_ADDR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= 1'b0;
      float_q <= 1'b0;
    end else if (hit_wr) begin
      mode_q  <= guarded_next(wdata[MODE_POS],  mode_q,  wdt_run);
      float_q <= guarded_next(wdata[FLOAT_POS], float_q, wdt_run);
    end
  end

  assign mode_sel  = mode_q;
  assign float_sel = float_q;

  always_comb begin
    rdata = '0;
    if (hit_rd) rdata = {mode_q, float_q, RSVD_HI_VAL, RSVD_LO_VAL};
  end

  p_no_set_mode_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_wr && wdt_run && !mode_q) |=> !mode_q);
  p_no_set_float_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_wr && wdt_run && !float_q) |=> !float_q);
  p_clear_mode_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_wr && !wdata[MODE_POS]) |=> !mode_q);
  p_clear_float_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_wr && !wdata[FLOAT_POS]) |=> !float_q);
  p_no_stray_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !hit_wr |=> ($stable(mode_q) && $stable(float_q)));
endmodule

// File: rtl/lpm_mode_fsm.sv
module lpm_mode_fsm
  import lpm_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic sleep_req,
  input  logic wake,
  input  logic mode_sel,
  input  logic float_sel,
  output logic sleep_flag,
  output logic stby_flag,
  output logic float_pins,
  output logic capture
);
  pm_state_e state_q, state_d;
  logic      float_q;
  logic      enter;

  assign enter = (state_q == PM_RUN) && sleep_req;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      PM_RUN:   if (sleep_req) state_d = mode_sel ? PM_STBY : PM_SLEEP;
      PM_SLEEP,
      PM_STBY:  if (wake) state_d = PM_RUN;
      default:  state_d = PM_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PM_RUN;
      float_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (enter) float_q <= float_sel;
    end
  end

  assign sleep_flag = (state_q == PM_SLEEP);
  assign stby_flag  = (state_q == PM_STBY);
  assign float_pins = float_q;
  assign capture    = enter && mode_sel && !float_sel;

  p_enter_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep_flag && !stby_flag && sleep_req) |=> (sleep_flag || stby_flag));
  p_flags_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((sleep_flag || stby_flag) && !wake) |=> ($stable(sleep_flag) && $stable(stby_flag)));
  p_wake_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((sleep_flag || stby_flag) && wake) |=> (!sleep_flag && !stby_flag));
endmodule

// File: rtl/lpm_pin_hold.sv
module lpm_pin_hold #(
  parameter int unsigned NUM_PINS = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                capture,
  input  logic                stby,
  input  logic                float_pins,
  input  logic [NUM_PINS-1:0] core_out,
  input  logic [NUM_PINS-1:0] core_oe,
  output logic [NUM_PINS-1:0] pad_out,
  output logic [NUM_PINS-1:0] pad_oe
);
  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    logic out_h, oe_h;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        out_h <= 1'b0;
        oe_h  <= 1'b0;
      end else if (capture) begin
        out_h <= core_out[i];
        oe_h  <= core_oe[i];
      end
    end

    always_comb begin
      if (stby && float_pins) begin
        pad_out[i] = core_out[i];
        pad_oe[i]  = 1'b0;
      end else if (stby) begin
        pad_out[i] = out_h;
        pad_oe[i]  = oe_h;
      end else begin
        pad_out[i] = core_out[i];
        pad_oe[i]  = core_oe[i];
      end
    end
  end
endmodule

// File: rtl/lpm_ctrl.sv
module lpm_ctrl
  import lpm_pkg::*;
#(
  parameter int unsigned ADDR_W   = 4,
  parameter int unsigned REG_ADDR = 0,
  parameter int unsigned NUM_PINS = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic                rd_en,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [REG_W-1:0]    wdata,
  output logic [REG_W-1:0]    rdata,
  input  logic                wdt_run,
  input  logic                sleep_req,
  input  logic                wake,
  input  logic [NUM_PINS-1:0] core_out,
  input  logic [NUM_PINS-1:0] core_oe,
  output logic [NUM_PINS-1:0] pad_out,
  output logic [NUM_PINS-1:0] pad_oe,
  output logic                sleep_flag,
  output logic                stby_flag
);
  logic mode_sel, float_sel, float_pins, capture;

  lpm_cfg_reg #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .wdt_run(wdt_run), .mode_sel(mode_sel),
    .float_sel(float_sel), .rdata(rdata)
  );

  lpm_mode_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .wake(wake),
    .mode_sel(mode_sel), .float_sel(float_sel), .sleep_flag(sleep_flag),
    .stby_flag(stby_flag), .float_pins(float_pins), .capture(capture)
  );

  lpm_pin_hold #(.NUM_PINS(NUM_PINS)) u_pins (
    .clk(clk), .rst_n(rst_n), .capture(capture), .stby(stby_flag),
    .float_pins(float_pins), .core_out(core_out), .core_oe(core_oe),
    .pad_out(pad_out), .pad_oe(pad_oe)
  );

  p_float_off_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (stby_flag && float_pins) |-> (pad_oe == '0));
  p_frozen_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (stby_flag && !float_pins && $past(stby_flag) && !$past(float_pins))
      |-> ($stable(pad_out) && $stable(pad_oe)));
  p_passthru_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !stby_flag |-> (pad_out == core_out && pad_oe == core_oe));
  p_one_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sleep_flag, stby_flag}));
endmodule

// File: tb/lpm_ctrl_bench.sv
module lpm_ctrl_bench;
  localparam int AW = 4;
  localparam int NP = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0, rd_en = 1'b0, wdt_run = 1'b0;
  logic          sleep_req = 1'b0, wake = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [7:0]    wdata = '0;
  logic [7:0]    rdata;
  logic [NP-1:0] core_out = '0, core_oe = '0, pad_out, pad_oe;
  logic          sleep_flag, stby_flag;

  int  n_run = 0, n_fail = 0, cyc = 0;
  bit  done = 1'b0;
  logic m_mode = 1'b0, m_float = 1'b0;

  always #2 clk = ~clk;

  lpm_ctrl #(.ADDR_W(AW), .REG_ADDR(0), .NUM_PINS(NP)) u_lpm_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .wdt_run(wdt_run), .sleep_req(sleep_req),
    .wake(wake), .core_out(core_out), .core_oe(core_oe), .pad_out(pad_out),
    .pad_oe(pad_oe), .sleep_flag(sleep_flag), .stby_flag(stby_flag)
  );

  function automatic logic nxt(input logic w, input logic cur, input logic wdt);
    return w ? (cur | ~wdt) : 1'b0;
  endfunction

  function automatic logic [7:0] exp_rd(input logic m, input logic f);
    return {m, f, 1'b0, 5'b11111};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d, input logic wdt);
    addr = a; wdata = d; wdt_run = wdt; wr_en = 1'b1;
    tick();
    wr_en = 1'b0;
    if (a == 0) begin
      m_mode  = nxt(d[7], m_mode, wdt);
      m_float = nxt(d[6], m_float, wdt);
    end
  endtask

  task automatic rd_chk(input string req);
    addr = '0; rd_en = 1'b1; #1;
    chk(req, rdata, exp_rd(m_mode, m_float));
    rd_en = 1'b0; #1;
  endtask

  task automatic pulse_sleep();
    sleep_req = 1'b1; tick(); sleep_req = 1'b0;
  endtask

  task automatic pulse_wake();
    wake = 1'b1; tick(); wake = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000 && !done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=%0d expected<=100000", cyc);
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) tick();
    rst_n = 1'b1;
    tick();

    // R1 reset state
    rd_chk("R1 reset read");
    chk("R1 flags at reset", {sleep_flag, stby_flag}, 2'b00);

    // R7 read strobe off and wrong address read zero
    #1 chk("R7 no strobe rdata", rdata, 0);
    addr = 4'd3; rd_en = 1'b1; #1 chk("R7 other addr rdata", rdata, 0); rd_en = 1'b0;

    // R2 plain writes
    wr(0, 8'hC0, 1'b0); rd_chk("R2 set both");
    wr(0, 8'h40, 1'b0); rd_chk("R2 clear mode keep float");
    wr(0, 8'h00, 1'b0); rd_chk("R2 clear both");

    // R3 R4 protected bits under watchdog
    wr(0, 8'h80, 1'b1); chk("R3 mode blocked", rdata, 0); rd_chk("R3 mode stays 0");
    wr(0, 8'h40, 1'b1); rd_chk("R4 float stays 0");

    // R5 clear allowed under watchdog
    wr(0, 8'hC0, 1'b0);
    wr(0, 8'hC0, 1'b1); rd_chk("R5 set held under wdt");
    wr(0, 8'h40, 1'b1); rd_chk("R5 mode cleared under wdt");
    wr(0, 8'h00, 1'b1); rd_chk("R5 float cleared under wdt");

    // R6 reserved bits
    wr(0, 8'h20, 1'b0); rd_chk("R6 reserved write 0x20");
    wr(0, 8'h1F ^ 8'h1F, 1'b0); rd_chk("R6 reserved write 0x00");

    // R7 write elsewhere ignored
    wr(4'd5, 8'hC0, 1'b0); rd_chk("R7 other addr write ignored");

    // random register traffic
    for (int i = 0; i < 300; i++) begin
      logic [AW-1:0] a;
      a = ($urandom % 4 == 0) ? AW'($urandom) : '0;
      wr(a, 8'($urandom), 1'($urandom));
      rd_chk("R2 R3 R4 R5 R6 random");
    end

    // R8 R13 sleep mode
    wr(0, 8'h00, 1'b0);
    core_out = 8'h12; core_oe = 8'hF0;
    pulse_sleep();
    chk("R8 sleep flags", {sleep_flag, stby_flag}, 2'b10);
    core_out = 8'h9C; core_oe = 8'h0F; #1;
    chk("R13 sleep pass out", pad_out, 8'h9C);
    chk("R13 sleep pass oe", pad_oe, 8'h0F);
    wr(0, 8'h80, 1'b0);
    pulse_sleep();
    chk("R10 req ignored in sleep", {sleep_flag, stby_flag}, 2'b10);
    repeat (5) tick();
    chk("R9 sleep held", {sleep_flag, stby_flag}, 2'b10);
    pulse_wake();
    chk("R9 wake clears sleep", {sleep_flag, stby_flag}, 2'b00);

    // R8 R11 standby with hold
    core_out = 8'hA5; core_oe = 8'h3C;
    pulse_sleep();
    chk("R8 standby flags", {sleep_flag, stby_flag}, 2'b01);
    for (int i = 0; i < 20; i++) begin
      core_out = 8'($urandom); core_oe = 8'($urandom);
      sleep_req = (i == 7);
      tick(); sleep_req = 1'b0;
      chk("R11 held out", pad_out, 8'hA5);
      chk("R11 held oe", pad_oe, 8'h3C);
    end
    chk("R10 req ignored in standby", {sleep_flag, stby_flag}, 2'b01);
    pulse_wake();
    chk("R9 wake clears standby", {sleep_flag, stby_flag}, 2'b00);
    core_out = 8'h77; core_oe = 8'h81; #1;
    chk("R13 after wake out", pad_out, 8'h77);
    chk("R13 after wake oe", pad_oe, 8'h81);

    // R12 standby with floating pins
    wr(0, 8'hC0, 1'b0);
    core_oe = 8'hFF;
    pulse_sleep();
    chk("R8 float standby flags", {sleep_flag, stby_flag}, 2'b01);
    for (int i = 0; i < 10; i++) begin
      core_oe = 8'($urandom) | 8'h01; tick();
      chk("R12 oe off", pad_oe, 0);
    end
    pulse_wake();
    #1 chk("R13 oe back", pad_oe, core_oe);

    finish_run();
  end
endmodule